// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a processor pipeline. Every slot can hold any page: a lookup compares the requested virtual page number and the current address-space number against all slots in the same cycle. It returns a hit flag, the slot index and the stored fields (physical page, per-privilege-mode read and write enable masks, fault-on-read and fault-on-write flags). A slot marked global matches in every address space.

New translations are written into the slot chosen by a rotating replacement pointer, which then steps on. A peek port shows the slot under the pointer and can step the pointer without writing. Three invalidation commands keep the contents coherent: clear everything, clear only the per-process (non-global) slots, or clear the slots that map one page in the current address space.

The depth is a parameter. Typical instances use 48 slots for instruction fetch and 64 for data. Page-table walking, fault generation and event counting are left to the surrounding logic.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is 0, and no lookup hits.
- R2: A lookup hits in the same cycle when a slot is valid, its tag equals `lk_vpn`, and either its global bit is set or its stored ASN equals `lk_asn`. On a hit the outputs carry that slot's index and fields. On a miss they are all zero.
- R3: An insert (`ins_valid`=1) writes the slot at the replacement pointer, overwriting whatever was there. The pointer then moves up by one.
- R4: The replacement pointer wraps from DEPTH-1 back to 0.
- R5: `flush_cmd`=1 (flush all) invalidates every slot and returns the pointer to 0.
- R6: `flush_cmd`=2 (flush local) invalidates every slot whose global bit is clear and leaves global slots valid and unchanged.
- R7: `flush_cmd`=3 (flush page) invalidates every valid slot whose tag equals `flush_vpn` and whose global bit is set or whose ASN equals `flush_asn`. No other slot changes.
- R8: The peek port shows the valid bit and fields of the slot under the pointer. `peek_adv`=1 moves the pointer on by one, with the same wrap, and leaves the contents unchanged.
- R9: When several slots match a lookup, the one with the lowest index is reported.
- R10: When a flush and an insert arrive in the same cycle, the flush acts first and the insert then writes its slot. After flush all, that slot is slot 0 and the pointer ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_global | output | 1 | Global bit of the matching slot |
| lk_rd_mask | output | MODE_N | Per-mode read enables |
| lk_wr_mask | output | MODE_N | Per-mode write enables |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_valid | input | 1 | Insert a translation this cycle |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | ASN to insert |
| ins_global | input | 1 | Global bit to insert |
| ins_rd_mask | input | MODE_N | Read enables to insert |
| ins_wr_mask | input | MODE_N | Write enables to insert |
| ins_fault_rd | input | 1 | Fault-on-read to insert |
| ins_fault_wr | input | 1 | Fault-on-write to insert |
| flush_cmd | input | 2 | 0 none, 1 all, 2 non-global, 3 one page |
| flush_vpn | input | VPN_W | Page for flush page |
| flush_asn | input | ASN_W | ASN for flush page |
| peek_adv | input | 1 | Step the pointer without writing |
| peek_idx | output | IDX_W | Current pointer value |
| peek_valid | output | 1 | Valid bit of the slot under the pointer |
| peek_vpn | output | VPN_W | Tag of the slot under the pointer |
| peek_ppn | output | PPN_W | Physical page of the slot under the pointer |
| peek_asn | output | ASN_W | ASN of the slot under the pointer |
| peek_global | output | 1 | Global bit of the slot under the pointer |

## Verification
The assertions check several pointer properties on every cycle: its range, its wrap, its step on advance and its return to zero on flush all. They also check that a hit always names a valid slot, that flushes never create valid slots, that an insert leaves its slot valid, and that flush all and flush local leave nothing they should have removed. Whether the right slot answered a lookup, under which address space, and with which fields can only be shown by the bench's scenarios, which compare against a reference model. The same holds for lowest-index priority among duplicates, for the exact set of slots a flush page removes, and for the ordering of flush and insert in one cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Invalidation command encoding carried on flush_cmd
   typedef enum logic [1:0] {
      FLUSH_NONE  = 2'd0,
      FLUSH_ALL   = 2'd1,
      FLUSH_LOCAL = 2'd2,
      FLUSH_PAGE  = 2'd3
   } flush_cmd_e;

endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
   parameter int DEPTH = 64,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr_q,
   output logic [IDX_W-1:0] slot
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [IDX_W-1:0] inc;
   logic [IDX_W-1:0] ptr_d;

   // Slot an insert lands in: a flush-all this cycle restarts from zero
   assign slot = clear ? '0 : ptr_q;

   generate
      if (POW2) begin : g_wrap_free
         assign inc = slot + 1'b1;
      end else begin : g_wrap_cmp
         assign inc = (slot == LAST) ? '0 : slot + 1'b1;
      end
   endgenerate

   assign ptr_d = advance ? inc : slot;

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

   a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && advance && ptr_q == LAST) |=> ptr_q == '0);

   a_r3_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && advance && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

   a_r5_ptr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !advance) |=> ptr_q == '0);

   a_r10_clear_then_step: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && advance) |=> ptr_q == IDX_W'(1));

endmodule

// File: rtl/tlb_store.sv
module tlb_store
   import tlb_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int VPN_W  = 30,
   parameter int PPN_W  = 28,
   parameter int ASN_W  = 8,
   parameter int MODE_N = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  flush_cmd_e        fcmd,
   input  logic [VPN_W-1:0]  fvpn,
   input  logic [ASN_W-1:0]  fasn,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [ASN_W-1:0]  wr_asn,
   input  logic              wr_glb,
   input  logic [MODE_N-1:0] wr_rdm,
   input  logic [MODE_N-1:0] wr_wrm,
   input  logic              wr_fr,
   input  logic              wr_fw,
   output logic [DEPTH-1:0]  valid_q,
   output logic [DEPTH-1:0]  glb_q,
   output logic [VPN_W-1:0]  tag_q [DEPTH],
   output logic [PPN_W-1:0]  ppn_q [DEPTH],
   output logic [ASN_W-1:0]  asn_q [DEPTH],
   output logic [MODE_N-1:0] rdm_q [DEPTH],
   output logic [MODE_N-1:0] wrm_q [DEPTH],
   output logic [DEPTH-1:0]  fr_q,
   output logic [DEPTH-1:0]  fw_q
);

   logic [DEPTH-1:0] kill;

   // Per-slot invalidation decision for this cycle's command
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         unique case (fcmd)
            FLUSH_ALL:   kill[i] = 1'b1;
            FLUSH_LOCAL: kill[i] = !glb_q[i];
            FLUSH_PAGE:  kill[i] = valid_q[i] && (tag_q[i] == fvpn) &&
                                   (glb_q[i] || (asn_q[i] == fasn));
            default:     kill[i] = 1'b0;
         endcase
      end
   end

   // Flush first, then the insert overwrites its slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         glb_q   <= '0;
         fr_q    <= '0;
         fw_q    <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i] <= '0;
            ppn_q[i] <= '0;
            asn_q[i] <= '0;
            rdm_q[i] <= '0;
            wrm_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (kill[i]) valid_q[i] <= 1'b0;
            if (wr_en && wr_idx == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
               glb_q[i]   <= wr_glb;
               tag_q[i]   <= wr_vpn;
               ppn_q[i]   <= wr_ppn;
               asn_q[i]   <= wr_asn;
               rdm_q[i]   <= wr_rdm;
               wrm_q[i]   <= wr_wrm;
               fr_q[i]    <= wr_fr;
               fw_q[i]    <= wr_fw;
            end
         end
      end
   end

   a_r5_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (fcmd == FLUSH_ALL && !wr_en) |=> valid_q == '0);

   a_r6_local_gone: assert property (@(posedge clk) disable iff (!rst_n)
      (fcmd == FLUSH_LOCAL && !wr_en) |=> (valid_q & ~glb_q) == '0);

   a_r6_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fcmd == FLUSH_LOCAL && !wr_en) |=> (valid_q & glb_q) == $past(valid_q & glb_q));

   a_r7_flush_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (valid_q & ~$past(valid_q)) == '0);

   a_r3_insert_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int DEPTH = 64,
   parameter int VPN_W = 30,
   parameter int ASN_W = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [VPN_W-1:0] q_vpn,
   input  logic [ASN_W-1:0] q_asn,
   input  logic [DEPTH-1:0] valid_q,
   input  logic [DEPTH-1:0] glb_q,
   input  logic [VPN_W-1:0] tag_q [DEPTH],
   input  logic [ASN_W-1:0] asn_q [DEPTH],
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   logic [DEPTH-1:0] match;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = valid_q[g] && (tag_q[g] == q_vpn) &&
                           (glb_q[g] || (asn_q[g] == q_asn));
      end
   endgenerate

   // Scan from the top so the lowest matching index is kept
   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |match;

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
   import tlb_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int VPN_W  = 30,
   parameter int PPN_W  = 28,
   parameter int ASN_W  = 8,
   parameter int MODE_N = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              lk_global,
   output logic [MODE_N-1:0] lk_rd_mask,
   output logic [MODE_N-1:0] lk_wr_mask,
   output logic              lk_fault_rd,
   output logic              lk_fault_wr,
   input  logic              ins_valid,
   input  logic [VPN_W-1:0]  ins_vpn,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [ASN_W-1:0]  ins_asn,
   input  logic              ins_global,
   input  logic [MODE_N-1:0] ins_rd_mask,
   input  logic [MODE_N-1:0] ins_wr_mask,
   input  logic              ins_fault_rd,
   input  logic              ins_fault_wr,
   input  logic [1:0]        flush_cmd,
   input  logic [VPN_W-1:0]  flush_vpn,
   input  logic [ASN_W-1:0]  flush_asn,
   input  logic              peek_adv,
   output logic [IDX_W-1:0]  peek_idx,
   output logic              peek_valid,
   output logic [VPN_W-1:0]  peek_vpn,
   output logic [PPN_W-1:0]  peek_ppn,
   output logic [ASN_W-1:0]  peek_asn,
   output logic              peek_global
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("asn_tlb: DEPTH must be at least 2");
      end
      if (VPN_W < 1 || PPN_W < 1 || ASN_W < 1) begin : g_bad_width
         $error("asn_tlb: field widths must be positive");
      end
      if (MODE_N < 1) begin : g_bad_modes
         $error("asn_tlb: MODE_N must be at least 1");
      end
   endgenerate

   flush_cmd_e       fcmd;
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] slot;
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;

   logic [DEPTH-1:0]  valid_q, glb_q, fr_q, fw_q;
   logic [VPN_W-1:0]  tag_q [DEPTH];
   logic [PPN_W-1:0]  ppn_q [DEPTH];
   logic [ASN_W-1:0]  asn_q [DEPTH];
   logic [MODE_N-1:0] rdm_q [DEPTH];
   logic [MODE_N-1:0] wrm_q [DEPTH];

   assign fcmd = flush_cmd_e'(flush_cmd);

   tlb_victim_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (fcmd == FLUSH_ALL),
      .advance (ins_valid || peek_adv),
      .ptr_q   (ptr_q),
      .slot    (slot)
   );

   tlb_store #(
      .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODE_N(MODE_N)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .fcmd    (fcmd),
      .fvpn    (flush_vpn),
      .fasn    (flush_asn),
      .wr_en   (ins_valid),
      .wr_idx  (slot),
      .wr_vpn  (ins_vpn),
      .wr_ppn  (ins_ppn),
      .wr_asn  (ins_asn),
      .wr_glb  (ins_global),
      .wr_rdm  (ins_rd_mask),
      .wr_wrm  (ins_wr_mask),
      .wr_fr   (ins_fault_rd),
      .wr_fw   (ins_fault_wr),
      .valid_q (valid_q),
      .glb_q   (glb_q),
      .tag_q   (tag_q),
      .ppn_q   (ppn_q),
      .asn_q   (asn_q),
      .rdm_q   (rdm_q),
      .wrm_q   (wrm_q),
      .fr_q    (fr_q),
      .fw_q    (fw_q)
   );

   tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_match (
      .q_vpn   (lk_vpn),
      .q_asn   (lk_asn),
      .valid_q (valid_q),
      .glb_q   (glb_q),
      .tag_q   (tag_q),
      .asn_q   (asn_q),
      .hit     (m_hit),
      .idx     (m_idx)
   );

   // Lookup result: fields of the winning slot, zero on a miss
   always_comb begin
      lk_hit      = m_hit;
      lk_idx      = '0;
      lk_ppn      = '0;
      lk_global   = 1'b0;
      lk_rd_mask  = '0;
      lk_wr_mask  = '0;
      lk_fault_rd = 1'b0;
      lk_fault_wr = 1'b0;
      if (m_hit) begin
         lk_idx      = m_idx;
         lk_ppn      = ppn_q[m_idx];
         lk_global   = glb_q[m_idx];
         lk_rd_mask  = rdm_q[m_idx];
         lk_wr_mask  = wrm_q[m_idx];
         lk_fault_rd = fr_q[m_idx];
         lk_fault_wr = fw_q[m_idx];
      end
   end

   assign peek_idx    = ptr_q;
   assign peek_valid  = valid_q[ptr_q];
   assign peek_vpn    = tag_q[ptr_q];
   assign peek_ppn    = ppn_q[ptr_q];
   assign peek_asn    = asn_q[ptr_q];
   assign peek_global = glb_q[ptr_q];

   a_r2_hit_names_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> valid_q[lk_idx]);

   a_r1_empty_after_reset: assert property (@(posedge clk)
      !rst_n |=> (valid_q == '0 && ptr_q == '0));

   a_r8_peek_keeps_contents: assert property (@(posedge clk) disable iff (!rst_n)
      (peek_adv && !ins_valid && fcmd == FLUSH_NONE) |=> $stable(valid_q));

endmodule

// File: tb/asn_tlb_test.sv
`timescale 1ns/1ps
module asn_tlb_test;

   localparam int DEPTH = 8;
   localparam int VPN_W = 4;
   localparam int PPN_W = 8;
   localparam int ASN_W = 2;
   localparam int MODE_N = 4;
   localparam int IDX_W = 3;

   logic clk = 0;
   logic rst_n = 0;
   always #2.5 clk = ~clk;

   logic [VPN_W-1:0] lk_vpn = '0;
   logic [ASN_W-1:0] lk_asn = '0;
   logic lk_hit, lk_global, lk_fault_rd, lk_fault_wr;
   logic [IDX_W-1:0] lk_idx;
   logic [PPN_W-1:0] lk_ppn;
   logic [MODE_N-1:0] lk_rd_mask, lk_wr_mask;
   logic ins_valid = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
   logic [VPN_W-1:0] ins_vpn = '0;
   logic [PPN_W-1:0] ins_ppn = '0;
   logic [ASN_W-1:0] ins_asn = '0;
   logic [MODE_N-1:0] ins_rd_mask = '0, ins_wr_mask = '0;
   logic [1:0] flush_cmd = 2'd0;
   logic [VPN_W-1:0] flush_vpn = '0;
   logic [ASN_W-1:0] flush_asn = '0;
   logic peek_adv = 0;
   logic [IDX_W-1:0] peek_idx;
   logic peek_valid, peek_global;
   logic [VPN_W-1:0] peek_vpn;
   logic [PPN_W-1:0] peek_ppn;
   logic [ASN_W-1:0] peek_asn;

   asn_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODE_N(MODE_N)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_ppn(lk_ppn), .lk_global(lk_global), .lk_rd_mask(lk_rd_mask),
      .lk_wr_mask(lk_wr_mask), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
      .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
      .ins_global(ins_global), .ins_rd_mask(ins_rd_mask), .ins_wr_mask(ins_wr_mask),
      .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
      .flush_cmd(flush_cmd), .flush_vpn(flush_vpn), .flush_asn(flush_asn),
      .peek_adv(peek_adv), .peek_idx(peek_idx), .peek_valid(peek_valid),
      .peek_vpn(peek_vpn), .peek_ppn(peek_ppn), .peek_asn(peek_asn),
      .peek_global(peek_global)
   );

   // Reference model
   bit              m_v [DEPTH];
   bit              m_g [DEPTH];
   bit              m_fr [DEPTH];
   bit              m_fw [DEPTH];
   logic [VPN_W-1:0] m_tag [DEPTH];
   logic [PPN_W-1:0] m_ppn [DEPTH];
   logic [ASN_W-1:0] m_asn [DEPTH];
   logic [MODE_N-1:0] m_rm [DEPTH];
   logic [MODE_N-1:0] m_wm [DEPTH];
   int m_ptr = 0;

   int checks = 0;
   int fails = 0;

   task automatic chk(string rq, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int model_find(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a)) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 0; m_g[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
         m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0; m_rm[i] = '0; m_wm[i] = '0;
      end
      m_ptr = 0;
   endtask

   // Flush first, then insert at the pointer, then step
   task automatic model_step();
      int base;
      for (int i = 0; i < DEPTH; i++) begin
         case (flush_cmd)
            2'd1: m_v[i] = 0;
            2'd2: if (!m_g[i]) m_v[i] = 0;
            2'd3: if (m_v[i] && m_tag[i] == flush_vpn && (m_g[i] || m_asn[i] == flush_asn)) m_v[i] = 0;
            default: ;
         endcase
      end
      base = (flush_cmd == 2'd1) ? 0 : m_ptr;
      if (ins_valid) begin
         m_v[base] = 1; m_g[base] = ins_global; m_tag[base] = ins_vpn; m_ppn[base] = ins_ppn;
         m_asn[base] = ins_asn; m_rm[base] = ins_rd_mask; m_wm[base] = ins_wr_mask;
         m_fr[base] = ins_fault_rd; m_fw[base] = ins_fault_wr;
      end
      if (ins_valid || peek_adv) m_ptr = (base == DEPTH - 1) ? 0 : base + 1;
      else m_ptr = base;
   endtask

   task automatic step(bit ins, int v, int p, int a, bit g, int cmd, int fv, int fa, bit adv);
      @(negedge clk);
      ins_valid = ins; ins_vpn = VPN_W'(v); ins_ppn = PPN_W'(p); ins_asn = ASN_W'(a);
      ins_global = g; ins_rd_mask = MODE_N'(p); ins_wr_mask = MODE_N'(p >> 4);
      ins_fault_rd = p[0]; ins_fault_wr = p[1];
      flush_cmd = 2'(cmd); flush_vpn = VPN_W'(fv); flush_asn = ASN_W'(fa); peek_adv = adv;
      @(posedge clk);
      model_step();
      #1;
      ins_valid = 0; flush_cmd = 2'd0; peek_adv = 0;
   endtask

   task automatic ins(int v, int p, int a, bit g);
      step(1, v, p, a, g, 0, 0, 0, 0);
   endtask

   task automatic check_lookup(string rq, int v, int a);
      int e;
      lk_vpn = VPN_W'(v); lk_asn = ASN_W'(a);
      #0.2;
      e = model_find(VPN_W'(v), ASN_W'(a));
      chk(rq, "hit", lk_hit, e >= 0);
      chk(rq, "idx", lk_idx, e >= 0 ? e : 0);
      chk(rq, "ppn", lk_ppn, e >= 0 ? m_ppn[e] : 0);
      chk(rq, "global", lk_global, e >= 0 ? m_g[e] : 0);
      chk(rq, "rd_mask", lk_rd_mask, e >= 0 ? m_rm[e] : 0);
      chk(rq, "wr_mask", lk_wr_mask, e >= 0 ? m_wm[e] : 0);
      chk(rq, "fault_rd", lk_fault_rd, e >= 0 ? m_fr[e] : 0);
      chk(rq, "fault_wr", lk_fault_wr, e >= 0 ? m_fw[e] : 0);
   endtask

   task automatic check_peek(string rq);
      #0.1;
      chk(rq, "peek_idx", peek_idx, m_ptr);
      chk(rq, "peek_valid", peek_valid, m_v[m_ptr]);
      if (m_v[m_ptr]) begin
         chk(rq, "peek_vpn", peek_vpn, m_tag[m_ptr]);
         chk(rq, "peek_ppn", peek_ppn, m_ppn[m_ptr]);
         chk(rq, "peek_asn", peek_asn, m_asn[m_ptr]);
         chk(rq, "peek_global", peek_global, m_g[m_ptr]);
      end
   endtask

   task automatic check_all(string rq);
      for (int v = 0; v < (1 << VPN_W); v++)
         for (int a = 0; a < (1 << ASN_W); a++)
            check_lookup(rq, v, a);
      check_peek(rq);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: empty after reset
      check_all("R1");

      // R2: ASN-qualified and global hits
      ins(3, 8'h5A, 1, 0);
      check_lookup("R2", 3, 1);
      check_lookup("R2", 3, 2);
      ins(5, 8'hC3, 0, 1);
      check_lookup("R2", 5, 3);
      check_all("R2");

      // R3 / R4: fill past the depth so the pointer wraps and slots are overwritten
      for (int k = 0; k < DEPTH; k++) begin
         ins(8 + (k % 4), 8'h10 + k, k % 4, k == 5);
         check_peek("R4");
      end
      check_all("R3");

      // R9: duplicate tags, lowest index wins
      ins(9, 8'hEE, 1, 1);
      ins(9, 8'hDD, 1, 1);
      check_lookup("R9", 9, 1);
      check_lookup("R9", 9, 0);

      // R6: drop non-global slots only
      step(0, 0, 0, 0, 0, 2, 0, 0, 0);
      check_all("R6");

      // R7: flush one page
      ins(7, 8'h71, 2, 0);
      ins(7, 8'h72, 3, 0);
      ins(6, 8'h61, 2, 0);
      step(0, 0, 0, 0, 0, 3, 7, 2, 0);
      check_all("R7");

      // R8: peek advance without writing
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      check_all("R8");
      for (int k = 0; k < DEPTH; k++) begin
         step(0, 0, 0, 0, 0, 0, 0, 0, 1);
         check_peek("R8");
      end

      // R10: flush page and insert together, then flush all with insert
      step(1, 7, 8'h99, 3, 0, 3, 7, 3, 0);
      check_all("R10");
      step(1, 2, 8'h22, 1, 0, 1, 0, 0, 0);
      check_all("R10");
      chk("R10", "ptr_after_flush_all_insert", peek_idx, 1);

      // R5: flush all
      step(0, 0, 0, 0, 0, 1, 0, 0, 0);
      check_all("R5");
      chk("R5", "ptr_zero", peek_idx, 0);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom % 20);
         step(r < 12, int'($urandom % 16), int'($urandom % 256), int'($urandom % 4),
              ($urandom % 4) == 0,
              (r >= 12 && r < 18) ? int'(1 + $urandom % 3) : ((r == 18) ? int'($urandom % 4) : 0),
              int'($urandom % 16), int'($urandom % 4), r == 19 || (r == 18));
         check_lookup("R2", int'($urandom % 16), int'($urandom % 4));
         check_lookup("R9", int'($urandom % 16), int'($urandom % 4));
         check_peek("R3");
      end
      check_all("R7");

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule